// File: doc/BRIEF.md
# Framer Status Latch Bank

This block holds two read-only 16-bit status words for an E1 framer's control bus. The first word is a set of event latches. Four of them capture a zero-to-one step on a live status bit: the one-second, 100 ms and 10 ms timers, and CRC-4 alignment. The fifth records that a receive signaling bit (ABCD) changed. The timer and signaling latches are evaluated on the basic-frame strobe. The alignment latch is evaluated on the 2 ms multiframe strobe. The event latches clear when software reads their own word or reads the companion interrupt-status word, which lives elsewhere on the bus.

The second word holds persistent alarm latches for remote alarm, AIS, loss of signal and basic frame alignment. Each one sets when its live alarm rises. A read clears a latch only when its live alarm has already dropped. While the alarm is still present, the latch stays set through every read.

A small read-port state machine decodes each bus read. Its states are RP_IDLE (no read), RP_EVT (event word), RP_PER (persistent word) and RP_OTHER (any other address, including the companion word). Every cycle the machine moves to the state that the current request decodes to, and it returns to RP_IDLE when no read is asserted. It captures the selected word in the cycle of the read and presents it on the next cycle.

Top module: `fsl_status_bank`

## Requirements
- R1: After reset, every event and persistent latch is zero, and the first reads of both words return 0.
- R2: Unused positions read as zero: bits 15..5 of the event word and bits 15..4 of the persistent word. A read of any address other than the two status words returns 0.
- R3: Event bits 0 (one-second), 1 (100 ms) and 2 (10 ms) set when their live bit is 1 at a basic-frame strobe and was 0 at the previous basic-frame strobe. A rise between strobes has no effect until the next basic-frame strobe.
- R4: Event bit 3 (CRC-4 alignment) is evaluated only at multiframe strobes. A rise of its live bit followed only by basic-frame strobes leaves bit 3 at 0.
- R5: Event bit 4 sets when the signaling-change input is 1 at a basic-frame strobe. Without a strobe, that input has no effect.
- R6: A live event bit that stays at 1 does not set its latch again after the latch has been cleared.
- R7: A read of the event address (EVT_ADDR, default 0x10) returns the event word and clears all event latches.
- R8: A read of the companion interrupt-status address (IRQ_ADDR, default 0x08) clears all event latches and returns 0 on this block's data output.
- R9: If an event sets in the same cycle as a clearing read, the set wins. The read returns the value held before that cycle.
- R10: Persistent bit 3 (remote alarm), bit 2 (AIS), bit 1 (loss of signal) and bit 0 (frame alignment) set on a zero-to-one step of the live bit, sampled every clock.
- R11: A read of the persistent address (PER_ADDR, default 0x11) returns the persistent word. It clears only the bits whose live alarm is 0 in the read cycle; the other bits stay set.
- R12: Read data appears on rd_data in the cycle after the cycle in which rd_en is sampled high, for one cycle. It is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bf_strobe | input | 1 | Basic-frame strobe, one clock wide |
| mf_strobe | input | 1 | 2 ms multiframe strobe, one clock wide |
| sec_live | input | 1 | Live one-second timer bit |
| t100_live | input | 1 | Live 100 ms timer bit |
| t10_live | input | 1 | Live 10 ms timer bit |
| align_live | input | 1 | Live CRC-4 alignment bit |
| sig_chg | input | 1 | Some receive ABCD bit changed in this frame |
| bfa_live | input | 1 | Live basic frame alignment alarm |
| los_live | input | 1 | Live loss-of-signal alarm |
| ais_live | input | 1 | Live AIS alarm |
| rai_live | input | 1 | Live remote alarm |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 8 | Bus read address |
| rd_data | output | 16 | Read data, one cycle after the read |

## Verification
A latch updates at the clock edge that samples its strobe or live input, and the effect is first visible on rd_data through a read one cycle later. Read data itself is due exactly one edge after rd_en is sampled and reflects the latch state before that edge. The bench drives inputs on falling edges, advances its behavioural model at each rising edge from those same inputs, and compares rd_data with the model on the following falling edge. Directed reads then check literal values at that same point.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

    // Read-port state: which word the last sampled bus read selected
    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_EVT   = 2'd1,
        RP_PER   = 2'd2,
        RP_OTHER = 2'd3
    } rp_state_e;

    // Event word bit positions (software decodes these)
    localparam int EVT_SEC   = 0;
    localparam int EVT_T100  = 1;
    localparam int EVT_T10   = 2;
    localparam int EVT_ALIGN = 3;
    localparam int EVT_SIG   = 4;
    localparam int EVT_W     = 5;

    // Persistent word bit positions
    localparam int PER_BFA = 0;
    localparam int PER_LOS = 1;
    localparam int PER_AIS = 2;
    localparam int PER_RAI = 3;
    localparam int PER_W   = 4;

endpackage

// File: rtl/fsl_evt_bit.sv
// One event latch. EDGE=1: set on 0->1 of live between strobes.
// EDGE=0: set whenever live is high at a strobe.
module fsl_evt_bit #(
    parameter bit EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic live,
    input  logic clr,
    output logic lat
);
    logic hit;

    generate
        if (EDGE) begin : g_edge
            logic hist_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      hist_q <= 1'b0;
                else if (strobe) hist_q <= live;
            end
            assign hit = strobe & live & ~hist_q;
        end else begin : g_level
            assign hit = strobe & live;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= 1'b0;
        else        lat <= hit | (lat & ~clr);
    end
endmodule

// File: rtl/fsl_per_bit.sv
// One persistent alarm latch: sets on a rise of live, and a read
// clears it only while live is low.
module fsl_per_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic rd_hit,
    output logic lat
);
    logic hist_q;
    logic rise;
    logic drop_ok;

    assign rise    = live & ~hist_q;
    assign drop_ok = rd_hit & ~live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
            lat    <= 1'b0;
        end else begin
            hist_q <= live;
            lat    <= rise | (lat & ~drop_ok);
        end
    end
endmodule

// File: rtl/fsl_read_port.sv
module fsl_read_port
    import fsl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter int          E_W      = 5,
    parameter int          P_W      = 4,
    parameter logic [7:0]  EVT_ADDR = 8'h10,
    parameter logic [7:0]  PER_ADDR = 8'h11,
    parameter logic [7:0]  IRQ_ADDR = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [E_W-1:0]    evt_q,
    input  logic [P_W-1:0]    per_q,
    output logic              clr_evt,
    output logic              clr_per,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(PER_ADDR);
    localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_ADDR);

    rp_state_e         state_q, state_d;
    logic [DATA_W-1:0] snap_q;

    // next-state decode
    always_comb begin
        state_d = RP_IDLE;
        if (rd_en) begin
            if (rd_addr == A_EVT)      state_d = RP_EVT;
            else if (rd_addr == A_PER) state_d = RP_PER;
            else                       state_d = RP_OTHER;
        end
    end

    assign clr_evt = rd_en && ((rd_addr == A_EVT) || (rd_addr == A_IRQ));
    assign clr_per = rd_en && (rd_addr == A_PER);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    // snapshot of the selected word, taken before any clear lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            unique case (state_d)
                RP_EVT:  snap_q <= {{(DATA_W-E_W){1'b0}}, evt_q};
                RP_PER:  snap_q <= {{(DATA_W-P_W){1'b0}}, per_q};
                default: snap_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RP_EVT, RP_PER:    rd_data = snap_q;
            RP_IDLE, RP_OTHER: rd_data = '0;
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fsl_status_bank.sv
module fsl_status_bank
    import fsl_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] EVT_ADDR = 8'h10,
    parameter logic [7:0] PER_ADDR = 8'h11,
    parameter logic [7:0] IRQ_ADDR = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bf_strobe,
    input  logic              mf_strobe,
    input  logic              sec_live,
    input  logic              t100_live,
    input  logic              t10_live,
    input  logic              align_live,
    input  logic              sig_chg,
    input  logic              bfa_live,
    input  logic              los_live,
    input  logic              ais_live,
    input  logic              rai_live,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [EVT_W-1:0] evt_q;
    logic [PER_W-1:0] per_q;
    logic [EVT_W-1:0] evt_live;
    logic [EVT_W-1:0] evt_stb;
    logic [PER_W-1:0] per_live;
    logic             clr_evt;
    logic             clr_per;

    always_comb begin
        evt_live            = '0;
        evt_live[EVT_SEC]   = sec_live;
        evt_live[EVT_T100]  = t100_live;
        evt_live[EVT_T10]   = t10_live;
        evt_live[EVT_ALIGN] = align_live;
        evt_live[EVT_SIG]   = sig_chg;
        evt_stb             = {EVT_W{bf_strobe}};
        evt_stb[EVT_ALIGN]  = mf_strobe;
        per_live            = '0;
        per_live[PER_BFA]   = bfa_live;
        per_live[PER_LOS]   = los_live;
        per_live[PER_AIS]   = ais_live;
        per_live[PER_RAI]   = rai_live;
    end

    generate
        for (genvar i = 0; i < EVT_W; i++) begin : g_evt
            fsl_evt_bit #(.EDGE(i != EVT_SIG)) u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (evt_stb[i]),
                .live   (evt_live[i]),
                .clr    (clr_evt),
                .lat    (evt_q[i])
            );
        end
        for (genvar j = 0; j < PER_W; j++) begin : g_per
            fsl_per_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .live   (per_live[j]),
                .rd_hit (clr_per),
                .lat    (per_q[j])
            );
        end
    endgenerate

    fsl_read_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .E_W      (EVT_W),
        .P_W      (PER_W),
        .EVT_ADDR (EVT_ADDR),
        .PER_ADDR (PER_ADDR),
        .IRQ_ADDR (IRQ_ADDR)
    ) u_rp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .evt_q   (evt_q),
        .per_q   (per_q),
        .clr_evt (clr_evt),
        .clr_per (clr_per),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/fsl_status_bank_chk.sv
module fsl_status_bank_chk #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] EVT_ADDR = 8'h10,
    parameter logic [7:0] PER_ADDR = 8'h11,
    parameter logic [7:0] IRQ_ADDR = 8'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bf_strobe,
    input logic              mf_strobe,
    input logic              bfa_live,
    input logic              rai_live,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [4:0]        evt_q,
    input logic [3:0]        per_q
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(PER_ADDR);
    localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_ADDR);

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[DATA_W-1:5] == '0); // R2
    AST_PER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_addr == A_PER) |=> rd_data[DATA_W-1:4] == '0); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> rd_data == '0); // R12
    AST_NO_SET_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!bf_strobe && !mf_strobe) |=> (evt_q & ~$past(evt_q)) == '0); // R3
    AST_EVT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_addr == A_EVT && !bf_strobe && !mf_strobe) |=> evt_q == '0); // R7
    AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_addr == A_IRQ && !bf_strobe && !mf_strobe) |=> evt_q == '0); // R8
    AST_EVT_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_addr == A_EVT) |=> rd_data == {{(DATA_W-5){1'b0}}, $past(evt_q)}); // R9
    AST_BFA_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (per_q[0] && bfa_live) |=> per_q[0]); // R11
    AST_RAI_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (per_q[3] && rai_live) |=> per_q[3]); // R11
endmodule

bind fsl_status_bank fsl_status_bank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EVT_ADDR (EVT_ADDR),
    .PER_ADDR (PER_ADDR),
    .IRQ_ADDR (IRQ_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bf_strobe (bf_strobe),
    .mf_strobe (mf_strobe),
    .bfa_live  (bfa_live),
    .rai_live  (rai_live),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .evt_q     (evt_q),
    .per_q     (per_q)
);

// File: tb/fsl_status_bank_test.sv
`timescale 1ns/1ps
module fsl_status_bank_test;
    localparam logic [7:0] A_EVT = 8'h10;
    localparam logic [7:0] A_PER = 8'h11;
    localparam logic [7:0] A_IRQ = 8'h08;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bf_strobe = 0, mf_strobe = 0;
    logic sec_live = 0, t100_live = 0, t10_live = 0, align_live = 0, sig_chg = 0;
    logic bfa_live = 0, los_live = 0, ais_live = 0, rai_live = 0;
    logic rd_en = 0;
    logic [7:0] rd_addr = 8'h00;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_tag = "R1";
    bit done = 0;

    // behavioural reference state
    bit [4:0]  m_evt;
    bit [3:0]  m_per;
    bit [2:0]  m_th;      // timer history at basic-frame strobes
    bit        m_ah;      // alignment history at multiframe strobes
    bit [3:0]  m_ph;      // alarm history every clock
    bit [15:0] m_rd;

    always #2 clk = ~clk;

    fsl_status_bank uut (
        .clk(clk), .rst_n(rst_n), .bf_strobe(bf_strobe), .mf_strobe(mf_strobe),
        .sec_live(sec_live), .t100_live(t100_live), .t10_live(t10_live),
        .align_live(align_live), .sig_chg(sig_chg), .bfa_live(bfa_live),
        .los_live(los_live), .ais_live(ais_live), .rai_live(rai_live),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_edge();
        bit [3:0] alive;
        bit [2:0] tl;
        bit [4:0] set;
        bit clr_e;
        if (!rst_n) begin
            m_evt = 0; m_per = 0; m_th = 0; m_ah = 0; m_ph = 0; m_rd = 0;
            return;
        end
        alive = {rai_live, ais_live, los_live, bfa_live};
        tl    = {t10_live, t100_live, sec_live};
        m_rd  = 0;
        if (rd_en && rd_addr == A_EVT) m_rd = {11'd0, m_evt};
        if (rd_en && rd_addr == A_PER) m_rd = {12'd0, m_per};
        set = 0;
        if (bf_strobe) begin
            set[2:0] = tl & ~m_th;
            set[4]   = sig_chg;
            m_th     = tl;
        end
        if (mf_strobe) begin
            set[3] = align_live & ~m_ah;
            m_ah   = align_live;
        end
        clr_e = rd_en && (rd_addr == A_EVT || rd_addr == A_IRQ);
        m_evt = set | (clr_e ? 5'd0 : m_evt);
        for (int k = 0; k < 4; k++) begin
            bit keep;
            keep = m_per[k] && !(rd_en && rd_addr == A_PER && !alive[k]);
            m_per[k] = (alive[k] && !m_ph[k]) || keep;
        end
        m_ph = alive;
    endtask

    // one clock: model advances at the rising edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        check(cur_tag, rd_data, m_rd);
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
        rd_en = 1; rd_addr = a;
        step();
        rd_en = 0; rd_addr = 8'h00;
        check(tag, rd_data, exp);
    endtask

    task automatic bf_pulse();
        bf_strobe = 1; step(); bf_strobe = 0;
    endtask

    task automatic mf_pulse();
        mf_strobe = 1; step(); mf_strobe = 0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: stuck, actual=running expected=finished");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();

        cur_tag = "R1";
        rd(A_EVT, 16'h0000, "R1");
        rd(A_PER, 16'h0000, "R1");

        cur_tag = "R3";
        sec_live = 1; step(); step();
        rd(A_EVT, 16'h0000, "R3 no strobe");
        bf_pulse();
        rd(A_EVT, 16'h0001, "R3 one-second");
        t100_live = 1; t10_live = 1;
        bf_pulse();
        rd(A_EVT, 16'h0006, "R3 timers");

        cur_tag = "R6";
        bf_pulse();
        rd(A_EVT, 16'h0000, "R6 held high");

        cur_tag = "R4";
        align_live = 1;
        bf_pulse();
        rd(A_EVT, 16'h0000, "R4 bf only");
        mf_pulse();
        rd(A_EVT, 16'h0008, "R4 multiframe");

        cur_tag = "R5";
        sig_chg = 1; step(); sig_chg = 0;
        rd(A_EVT, 16'h0000, "R5 no strobe");
        sig_chg = 1; bf_pulse(); sig_chg = 0;
        rd(A_EVT, 16'h0010, "R5 change");

        cur_tag = "R8";
        sec_live = 0; bf_pulse();
        sec_live = 1; bf_pulse();
        rd(A_IRQ, 16'h0000, "R8 data");
        rd(A_EVT, 16'h0000, "R8 cleared");

        cur_tag = "R9";
        sig_chg = 1; bf_pulse(); sig_chg = 0;
        sec_live = 0; bf_pulse();
        rd(A_EVT, 16'h0010, "R7 read");
        sec_live = 1; bf_strobe = 1;
        rd(A_EVT, 16'h0000, "R9 old value");
        bf_strobe = 0;
        rd(A_EVT, 16'h0001, "R9 set wins");

        cur_tag = "R2";
        rd(8'h55, 16'h0000, "R2 other address");

        cur_tag = "R10";
        rai_live = 1; step();
        rd(A_PER, 16'h0008, "R10 remote alarm");
        rd(A_PER, 16'h0008, "R11 sticky while live");
        rai_live = 0; step();
        rd(A_PER, 16'h0008, "R11 last read");
        rd(A_PER, 16'h0000, "R11 cleared");
        los_live = 1; ais_live = 1; bfa_live = 1; step();
        ais_live = 0; los_live = 0;
        rd(A_PER, 16'h0007, "R10 three alarms");
        rd(A_PER, 16'h0001, "R11 partial clear");
        cur_tag = "R12";
        step();
        check("R12 idle", rd_data, 16'h0000);

        // random traffic against the model
        cur_tag = "R10 random";
        for (int n = 0; n < 2000; n++) begin
            bit [15:0] r;
            r = 16'($urandom);
            bf_strobe = r[0] & r[1]; mf_strobe = r[2] & r[3] & r[4];
            sec_live = r[5]; t100_live = r[6]; t10_live = r[7];
            align_live = r[8]; sig_chg = r[9];
            bfa_live = r[10]; los_live = r[11]; ais_live = r[12]; rai_live = r[13];
            rd_en = r[14];
            case (r[15] ^ r[0] ? r[2:1] : r[4:3])
                2'd0: rd_addr = A_EVT;
                2'd1: rd_addr = A_PER;
                2'd2: rd_addr = A_IRQ;
                default: rd_addr = 8'h3c;
            endcase
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule